// File: doc/BRIEF.md
# Two-Phase Barrier Synchroniser

This block holds a group of requesters, such as cores or hardware threads, at a common synchronisation point until every one of them has arrived. Then it lets all of them go in the same cycle. A requester announces its arrival by raising its request line. It keeps that line high while it waits, and it sees its release line rise once the whole group is in.

The unit keeps one shared tally and moves between two phases. In the gathering phase, arrivals are accepted one per cycle and the tally counts up. When the last member is accepted, the unit switches to the draining phase and raises every release line. In the draining phase, each requester leaves by lowering its request. One departure is taken per cycle and the tally counts down. Arrivals are refused during draining. Only when the tally returns to zero does the unit go back to gathering. This means a requester that finishes quickly cannot enter the next barrier while slower requesters are still leaving the current one.

Top module: `barrier_sync`

## Requirements
- R1: Reset clears the tally to zero, puts the unit in the gathering phase (`phase_o` = 0) and drives every `release_o` bit low.
- R2: While fewer than `N_REQ` arrivals have been accepted, no `release_o` bit rises and `phase_o` stays 0.
- R3: In the cycle after the `N_REQ`-th arrival is accepted, every `release_o` bit is 1 and `phase_o` is 1 (draining).
- R4: The tally changes by at most one per cycle. When several arrivals or departures are eligible together, the lowest-numbered requester is served first and the others wait.
- R5: A released requester keeps its `release_o` bit high for as long as it holds its request high.
- R6: A released requester that lowers its request departs. Its `release_o` bit falls in the next cycle, provided no lower-numbered departure is taken in the same cycle.
- R7: While `phase_o` is 1, a request from a requester that has already departed is ignored. It is accepted only after the unit returns to gathering.
- R8: In the cycle after the last departure, `phase_o` returns to 0.
- R9: A waiting requester that holds its request over many cycles is counted once. Repeated cycles of that request do not add to the tally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_req | input | N_REQ | Per-requester arrival request; lowering it after release means departure |
| release_o | output | N_REQ | Per-requester release, high from barrier completion until departure |
| phase_o | output | 1 | Current phase: 0 gathering, 1 draining |

## Verification
The assertions assume that a requester, once accepted, keeps its request high until it has been released. Under that assumption a waiting requester can never drop out of a barrier that has already counted it. Every stimulus vector and directed sequence in the bench keeps to this rule. Requests are lowered only in bits whose release is already high, or before the request has been accepted. Re-raised requests during draining, simultaneous drops and a reset in the middle of a barrier are all applied without ever withdrawing an accepted but unreleased arrival.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_REL  = 2'd2
    } slot_state_e;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_DRAIN  = 1'b1
    } phase_e;

endpackage

// File: rtl/barrier_pick.sv
module barrier_pick #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cand_i,
    output logic [WIDTH-1:0] gnt_o
);
    // lowest set bit wins
    always_comb begin
        gnt_o = cand_i & ~(cand_i - WIDTH'(1));
    end
endmodule

// File: rtl/barrier_slot.sv
module barrier_slot
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic release_all_i,
    input  logic depart_i,
    output logic idle_o,
    output logic rel_o
);
    slot_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (accept_i) state_d = release_all_i ? SLOT_REL : SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (release_all_i) state_d = SLOT_REL;
            end
            SLOT_REL: begin
                if (depart_i) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    assign idle_o = (state_q == SLOT_IDLE);
    assign rel_o  = (state_q == SLOT_REL);

    // R5: release is held until a departure is taken
    a_r5_release_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o && !depart_i) |=> rel_o);

    // R6: release only falls after a granted departure
    a_r6_fall_on_depart: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_o) |-> $past(depart_i));

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barrier_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] arrive_req,
    output logic [N_REQ-1:0] release_o,
    output logic             phase_o
);
    localparam int CNT_W = $clog2(N_REQ + 1);
    localparam logic [CNT_W-1:0] LAST_IN  = CNT_W'(N_REQ - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_REQ);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        phase_e           phase;
    } core_t;

    core_t core_d, core_q;

    logic [N_REQ-1:0] slot_idle;
    logic [N_REQ-1:0] slot_rel;
    logic [N_REQ-1:0] arr_cand, dep_cand;
    logic [N_REQ-1:0] arr_gnt, dep_gnt;
    logic             take_arr, take_dep;
    logic             last_arr, last_dep;

    always_comb begin
        arr_cand = (core_q.phase == PH_GATHER) ? (arrive_req & slot_idle) : '0;
        dep_cand = (core_q.phase == PH_DRAIN)  ? (~arrive_req & slot_rel) : '0;
    end

    barrier_pick #(.WIDTH(N_REQ)) u_arr_pick (.cand_i(arr_cand), .gnt_o(arr_gnt));
    barrier_pick #(.WIDTH(N_REQ)) u_dep_pick (.cand_i(dep_cand), .gnt_o(dep_gnt));

    always_comb begin
        take_arr = |arr_gnt;
        take_dep = |dep_gnt;
        last_arr = take_arr && (core_q.count == LAST_IN);
        last_dep = take_dep && (core_q.count == CNT_W'(1));

        core_d = core_q;
        if (take_arr) core_d.count = core_q.count + CNT_W'(1);
        else if (take_dep) core_d.count = core_q.count - CNT_W'(1);
        if (last_arr) core_d.phase = PH_DRAIN;
        else if (last_dep) core_d.phase = PH_GATHER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.count <= '0;
            core_q.phase <= PH_GATHER;
        end else begin
            core_q <= core_d;
        end
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        barrier_slot u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .accept_i     (arr_gnt[g]),
            .release_all_i(last_arr),
            .depart_i     (dep_gnt[g]),
            .idle_o       (slot_idle[g]),
            .rel_o        (slot_rel[g])
        );
    end

    assign release_o = slot_rel;
    assign phase_o   = core_q.phase;

    // R4: tally moves by at most one per cycle
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_q.count == $past(core_q.count)) ||
                 (core_q.count == $past(core_q.count) + CNT_W'(1)) ||
                 (core_q.count == $past(core_q.count) - CNT_W'(1)));

    // R2: tally never exceeds the group size
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.count <= FULL_CNT);

    // R3: draining is entered only with a full tally, all released
    a_r3_full_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_o) |-> (core_q.count == FULL_CNT) && (&release_o));

    // R8: gathering resumes only with an empty tally
    a_r8_empty_on_gather: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_o) |-> (core_q.count == '0) && (release_o == '0));

    // R2: releases are confined to the draining phase
    a_r2_release_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> phase_o);

    // R7: no arrival is granted while draining
    a_r7_no_arrival_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o |-> (arr_gnt == '0));

    // R4: at most one grant of either kind per cycle
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_gnt, dep_gnt}));

endmodule

// File: tb/barrier_sync_bench.sv
module barrier_sync_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive_req = '0;
    logic [N-1:0] release_o;
    logic         phase_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    barrier_sync #(.N_REQ(N)) u_barrier_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_req(arrive_req),
        .release_o (release_o),
        .phase_o   (phase_o)
    );

    // {request applied, release expected after the edge, phase expected}
    localparam int NV = 21;
    localparam logic [8:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 1'b0},  // 0  R1 idle
        {4'b1111, 4'b0000, 1'b0},  // 1  R4 one accepted
        {4'b1111, 4'b0000, 1'b0},  // 2  R4
        {4'b1111, 4'b0000, 1'b0},  // 3  R2 three in
        {4'b1111, 4'b1111, 1'b1},  // 4  R3 fourth in
        {4'b1111, 4'b1111, 1'b1},  // 5  R5 held
        {4'b1110, 4'b1110, 1'b1},  // 6  R6 req0 departs
        {4'b1111, 4'b1110, 1'b1},  // 7  R7 req0 back, ignored
        {4'b1001, 4'b1100, 1'b1},  // 8  R4 req1 before req2
        {4'b1001, 4'b1000, 1'b1},  // 9  R6 req2
        {4'b0001, 4'b0000, 1'b0},  // 10 R8 last out
        {4'b0001, 4'b0000, 1'b0},  // 11 R7 req0 accepted now
        {4'b0001, 4'b0000, 1'b0},  // 12 R9 held, counted once
        {4'b0011, 4'b0000, 1'b0},  // 13 R9
        {4'b0111, 4'b0000, 1'b0},  // 14 R9
        {4'b0111, 4'b0000, 1'b0},  // 15 R2 still three
        {4'b1111, 4'b1111, 1'b1},  // 16 R3
        {4'b0000, 4'b1110, 1'b1},  // 17 R4 one departure per cycle
        {4'b0000, 4'b1100, 1'b1},  // 18 R4
        {4'b0000, 4'b1000, 1'b1},  // 19 R4
        {4'b0000, 4'b0000, 1'b0}   // 20 R8
    };

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: release/phase actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step_check(input string tag, input logic [N-1:0] req,
                              input logic [N-1:0] rel, input logic ph);
        @(negedge clk);
        arrive_req = req;
        @(posedge clk);
        #1;
        check(tag, {release_o, phase_o}, {rel, ph});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", {release_o, phase_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step_check($sformatf("R%0s vector %0d", "x", i),
                       VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
        end

        // R1: reset during a partly filled barrier
        step_check("R2 partial fill", 4'b0011, 4'b0000, 1'b0);
        step_check("R2 partial fill", 4'b0111, 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        arrive_req = '0;
        #1;
        check("R1 reset mid barrier", {release_o, phase_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: tally truly cleared, so four fresh arrivals are needed
        step_check("R1 tally cleared", 4'b1111, 4'b0000, 1'b0);
        step_check("R1 tally cleared", 4'b1111, 4'b0000, 1'b0);
        step_check("R1 tally cleared", 4'b1111, 4'b0000, 1'b0);
        step_check("R3 full after reset", 4'b1111, 4'b1111, 1'b1);
        // R6: top requester departs first, lower ones still held
        step_check("R6 single drop", 4'b0111, 4'b0111, 1'b1);
        step_check("R5 others held", 4'b0111, 4'b0111, 1'b1);
        step_check("R6 drop", 4'b0000, 4'b0110, 1'b1);
        step_check("R6 drop", 4'b0000, 4'b0100, 1'b1);
        step_check("R8 back to gather", 4'b0000, 4'b0000, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule